// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Peripheral Pin Ownership

This block runs a small bank of general-purpose pins behind a four-register bus. Software sets an output latch, a per-pin direction mask, a per-pin pull-up request and a per-pin slew-limit request. The block turns these into the control signals of each pad: drive enable, drive value, pull-up enable and slew enable. The level on each pad comes back through a two-flop synchronizer, and a data-register read shows it on every pin that is an input.

Two on-chip serial engines, a UART and an SPI unit, can take over individual pins through per-pin claim masks. On a claimed pin the engine's own output enable and output value go to the pad, and the direction bit has no effect on driving. The pull-up still follows the direction bit, so an engine's receive or select pin keeps its pull-up when that pin's direction bit is 0. If both engines claim the same pin, the UART has priority.

The register bus has a 2-bit address, a write strobe and a read-data port. Read data is registered, so it appears one cycle after the address is presented.

Top module: `gpio_override_port`

## Requirements
- R1: While reset is asserted and right after it is released, the latch, direction, pull-up and slew registers all hold 0. With no peripheral claim, padOe, padPullEn and padSlewEn are all 0, and every register reads 0.
- R2: The register map is address 0 = data latch, 1 = direction, 2 = pull-up enable, 3 = slew enable. Read bits 7:6 of every register are always 0, even after writing 0xFF. Bits 5:0 map to pins 5:0.
- R3: A read of address 0 returns the latch bit for each pin whose direction bit is 1, and the synchronized pad level for each pin whose direction bit is 0.
- R4: A write to address 0 updates all six latch bits, including the bits of input pins. When such a pin later becomes an output, it drives the stored value.
- R5: On an unclaimed pin, padOe equals the pin's direction bit and padDo equals its latch bit.
- R6: On a pin whose uartClaim bit is 1, padOe and padDo come from uartOe and uartDo whatever the direction bit is. On a pin claimed only by spiClaim, they come from spiOe and spiDo. The UART wins when both engines claim a pin.
- R7: padPullEn for a pin is 1 only when its pull-up bit is 1 and its direction bit is 0. This holds for claimed pins as well.
- R8: padSlewEn for a pin is 1 only when its slew bit is 1 and the pad is being driven (padOe is 1), on both GPIO and peripheral-driven pins.
- R9: regRdData shows the register selected by regAddr in the cycle after that address is presented. A pad level change reaches a data read no sooner than the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data |
| uartClaim | input | 6 | Per-pin UART ownership |
| uartOe | input | 6 | UART output enables |
| uartDo | input | 6 | UART output values |
| spiClaim | input | 6 | Per-pin SPI ownership |
| spiOe | input | 6 | SPI output enables |
| spiDo | input | 6 | SPI output values |
| padIn | input | 6 | Pad levels, asynchronous |
| padOe | output | 6 | Pad drive enables |
| padDo | output | 6 | Pad drive values |
| padPullEn | output | 6 | Pad pull-up enables |
| padSlewEn | output | 6 | Pad slew-limit enables |

## Verification
The bench builds the block with its default parameters: six pins, 8-bit registers and two synchronizer stages. With these values the two unused register bits are visible on the bus, so the bench can show that they read as zero. The fixed synchronizer depth lets it sample a pad change at the exact cycle it first reaches a read. Five vectors mix direction masks, latch values and pad levels to exercise the per-pin read select. Directed cases then cover reset, claimed pins against direction, the UART-over-SPI priority, and pull-up and slew gating on claimed pins.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int ADDR_WIDTH = 2;

  typedef enum logic [ADDR_WIDTH-1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PULL  = 2'd2,
    SEL_SLEW  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLatch;
    logic    wrDir;
    logic    wrPull;
    logic    wrSlew;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
(
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWrEn,
  output ctrlStrobe_t           strobe
);
  regSel_e sel;

  always_comb begin
    sel            = regSel_e'(regAddr);
    strobe.rdSel   = sel;
    strobe.wrLatch = regWrEn && (sel == SEL_LATCH);
    strobe.wrDir   = regWrEn && (sel == SEL_DIR);
    strobe.wrPull  = regWrEn && (sel == SEL_PULL);
    strobe.wrSlew  = regWrEn && (sel == SEL_SLEW);
  end
endmodule

// File: rtl/gpio_ovr_datapath.sv
module gpio_ovr_datapath
  import gpio_ovr_pkg::*;
#(
  parameter int PIN_COUNT   = 6,
  parameter int REG_WIDTH   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [REG_WIDTH-1:0] regWrData,
  output logic [REG_WIDTH-1:0] regRdData,
  input  logic [PIN_COUNT-1:0] uartClaim,
  input  logic [PIN_COUNT-1:0] uartOe,
  input  logic [PIN_COUNT-1:0] uartDo,
  input  logic [PIN_COUNT-1:0] spiClaim,
  input  logic [PIN_COUNT-1:0] spiOe,
  input  logic [PIN_COUNT-1:0] spiDo,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padDo,
  output logic [PIN_COUNT-1:0] padPullEn,
  output logic [PIN_COUNT-1:0] padSlewEn
);
  localparam int PAD_BITS = REG_WIDTH - PIN_COUNT;

  logic [PIN_COUNT-1:0] latchQ, dirQ, pullQ, slewQ;
  logic [PIN_COUNT-1:0] pinSync, pinView;
  logic [PIN_COUNT-1:0] rdNext;
  logic                 unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_WIDTH-1:PIN_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
      pullQ  <= '0;
      slewQ  <= '0;
    end else begin
      if (strobe.wrLatch) latchQ <= regWrData[PIN_COUNT-1:0];
      if (strobe.wrDir)   dirQ   <= regWrData[PIN_COUNT-1:0];
      if (strobe.wrPull)  pullQ  <= regWrData[PIN_COUNT-1:0];
      if (strobe.wrSlew)  slewQ  <= regWrData[PIN_COUNT-1:0];
    end
  end

  gpio_ovr_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (pinSync)
  );

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      always_comb begin
        if (uartClaim[p]) begin
          padOe[p] = uartOe[p];
          padDo[p] = uartDo[p];
        end else if (spiClaim[p]) begin
          padOe[p] = spiOe[p];
          padDo[p] = spiDo[p];
        end else begin
          padOe[p] = dirQ[p];
          padDo[p] = latchQ[p];
        end
        padPullEn[p] = pullQ[p] & ~dirQ[p];
        padSlewEn[p] = slewQ[p] & padOe[p];
        pinView[p]   = dirQ[p] ? latchQ[p] : pinSync[p];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_LATCH: rdNext = pinView;
      SEL_DIR:   rdNext = dirQ;
      SEL_PULL:  rdNext = pullQ;
      SEL_SLEW:  rdNext = slewQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= {{PAD_BITS{1'b0}}, rdNext};
  end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_ovr_pkg::*;
#(
  parameter int PIN_COUNT   = 6,
  parameter int REG_WIDTH   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [REG_WIDTH-1:0]  regWrData,
  output logic [REG_WIDTH-1:0]  regRdData,
  input  logic [PIN_COUNT-1:0]  uartClaim,
  input  logic [PIN_COUNT-1:0]  uartOe,
  input  logic [PIN_COUNT-1:0]  uartDo,
  input  logic [PIN_COUNT-1:0]  spiClaim,
  input  logic [PIN_COUNT-1:0]  spiOe,
  input  logic [PIN_COUNT-1:0]  spiDo,
  input  logic [PIN_COUNT-1:0]  padIn,
  output logic [PIN_COUNT-1:0]  padOe,
  output logic [PIN_COUNT-1:0]  padDo,
  output logic [PIN_COUNT-1:0]  padPullEn,
  output logic [PIN_COUNT-1:0]  padSlewEn
);
  ctrlStrobe_t strobe;

  gpio_ovr_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_ovr_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .REG_WIDTH   (REG_WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .uartClaim (uartClaim),
    .uartOe    (uartOe),
    .uartDo    (uartDo),
    .spiClaim  (spiClaim),
    .spiOe     (spiOe),
    .spiDo     (spiDo),
    .padIn     (padIn),
    .padOe     (padOe),
    .padDo     (padDo),
    .padPullEn (padPullEn),
    .padSlewEn (padSlewEn)
  );
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
  parameter int PIN_COUNT = 6,
  parameter int REG_WIDTH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [REG_WIDTH-1:0] regRdData,
  input logic [PIN_COUNT-1:0] uartClaim,
  input logic [PIN_COUNT-1:0] uartOe,
  input logic [PIN_COUNT-1:0] uartDo,
  input logic [PIN_COUNT-1:0] spiClaim,
  input logic [PIN_COUNT-1:0] spiOe,
  input logic [PIN_COUNT-1:0] spiDo,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] padDo,
  input logic [PIN_COUNT-1:0] padPullEn,
  input logic [PIN_COUNT-1:0] padSlewEn
);
  logic [PIN_COUNT-1:0] spiOnly;
  assign spiOnly = spiClaim & ~uartClaim;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (padPullEn == '0) && ((padOe & ~(uartClaim | spiClaim)) == '0)); // R1

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_WIDTH-1:PIN_COUNT] == '0); // R2

  AST_UART_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ uartOe) | (padDo ^ uartDo)) & uartClaim) == '0); // R6

  AST_SPI_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ spiOe) | (padDo ^ spiDo)) & spiOnly) == '0); // R6

  AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (padPullEn & padOe & ~(uartClaim | spiClaim)) == '0); // R7

  AST_SLEW_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (padSlewEn & ~padOe) == '0); // R8
endmodule

bind gpio_override_port gpio_ovr_chk #(
  .PIN_COUNT (PIN_COUNT),
  .REG_WIDTH (REG_WIDTH)
) u_chk (.*);

// File: tb/gpio_override_port_tb.sv
module gpio_override_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {dir, latch, pad, expOe, expDo, expRead}, 6 bits each
  localparam logic [35:0] VEC [NVEC] = '{
    {6'h3F, 6'h2A, 6'h00, 6'h3F, 6'h2A, 6'h2A},
    {6'h00, 6'h15, 6'h33, 6'h00, 6'h15, 6'h33},
    {6'h0F, 6'h3C, 6'h30, 6'h0F, 6'h3C, 6'h3C},
    {6'h38, 6'h07, 6'h2D, 6'h38, 6'h07, 6'h05},
    {6'h21, 6'h3F, 6'h1E, 6'h21, 6'h3F, 6'h3F}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [5:0] uartClaim = '0, uartOe = '0, uartDo = '0;
  logic [5:0] spiClaim = '0, spiOe = '0, spiDo = '0;
  logic [5:0] padIn = '0;
  logic [5:0] padOe, padDo, padPullEn, padSlewEn;
  int checks = 0;
  int failures = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_override_port u_dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {2'b0, padOe}, 8'h00);
    check("R1 pull in reset", {2'b0, padPullEn}, 8'h00);
    rstN = 1'b1;
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], rd);
      check("R1 reg after reset", rd, 8'h00);
    end
    check("R1 slew after reset", {2'b0, padSlewEn}, 8'h00);

    // vector table: R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      writeReg(2'd1, {2'b0, VEC[v][35:30]});
      writeReg(2'd0, {2'b0, VEC[v][29:24]});
      padIn = VEC[v][23:18];
      repeat (3) @(negedge clk);
      check("R5 vector oe", {2'b0, padOe}, {2'b0, VEC[v][17:12]});
      check("R5 vector do", {2'b0, padDo}, {2'b0, VEC[v][11:6]});
      readReg(2'd0, rd);
      check("R3 vector read", rd, {2'b0, VEC[v][5:0]});
    end

    // R2: upper bits read zero
    for (int a = 0; a < 4; a++) begin
      writeReg(a[1:0], 8'hFF);
      readReg(a[1:0], rd);
      check("R2 upper bits", rd, 8'h3F);
    end

    // R9: read latency and synchronizer depth
    writeReg(2'd1, 8'h00);
    padIn = 6'h00;
    repeat (4) @(negedge clk);
    regAddr = 2'd0;
    @(negedge clk);
    padIn = 6'h3F;
    @(negedge clk);
    check("R9 first edge", regRdData, 8'h00);
    @(negedge clk);
    check("R9 second edge", regRdData, 8'h00);
    @(negedge clk);
    check("R9 third edge", regRdData, 8'h3F);
    writeReg(2'd2, 8'h15);
    regAddr = 2'd2;
    @(negedge clk);
    check("R9 one-cycle read", regRdData, 8'h15);

    // R4: latch written while inputs, driven later
    writeReg(2'd0, 8'h2D);
    check("R4 no drive as input", {2'b0, padOe}, 8'h00);
    writeReg(2'd1, 8'h3F);
    check("R4 stored value driven", {2'b0, padDo}, 8'h2D);

    // R6: ownership and priority
    writeReg(2'd0, 8'h3F);
    writeReg(2'd1, 8'h00);
    uartClaim = 6'h03; uartOe = 6'h01; uartDo = 6'h03;
    spiClaim = 6'h06; spiOe = 6'h3F; spiDo = 6'h00;
    @(negedge clk);
    check("R6 claimed oe dir0", {2'b0, padOe}, 8'h05);
    check("R6 claimed do", {2'b0, padDo}, 8'h3B);
    writeReg(2'd1, 8'h3F);
    check("R6 dir ignored on claim", {2'b0, padOe}, 8'h3D);

    // R7: pull-up gated by direction, also on claimed pins
    writeReg(2'd2, 8'h3F);
    writeReg(2'd1, 8'h0C);
    check("R7 pull gating", {2'b0, padPullEn}, 8'h33);
    uartClaim = '0; spiClaim = '0;
    @(negedge clk);
    check("R7 pull unclaimed", {2'b0, padPullEn}, 8'h33);

    // R8: slew only on driven pins, incl. peripheral
    writeReg(2'd3, 8'h3F);
    writeReg(2'd1, 8'h0F);
    check("R8 slew gpio", {2'b0, padSlewEn}, 8'h0F);
    spiClaim = 6'h30; spiOe = 6'h10;
    @(negedge clk);
    check("R8 slew peripheral", {2'b0, padSlewEn}, 8'h1F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule